// File: doc/BRIEF.md
# Coherent Input Period Capture Channel

This block is one channel of a timer that measures the period of an input signal that has already been filtered. It watches for edges of one chosen polarity. On each such edge it stores the value of a shared free-running counter bus. It keeps four storage stages. Two of them hold the newest timestamp. The other two hold the older timestamp that starts the period. A flag goes high once the start and the end of a full period are both held.

Software reads the newest timestamp from an A port and the start of the period from a B port. Reading the A port copies the matching start value into the B-port stage and then freezes that stage. It stays frozen until the B port is read. So an A read followed by a B read always returns the two ends of the same period, even when new edges arrive between the reads. The mode enable clears the first-capture state, the freeze and the flag whenever the channel leaves the mode.

Top module: `period_capture_channel`

## Requirements
- R1: When enabled, a capture happens in the clock cycle where `sig_i` is at the selected level (`edge_pol_i` = 1 for rising, 0 for falling) and the registered copy of `sig_i` from the previous cycle is not. Edges of the other polarity and a level that stays put cause no capture. The registered copy is 0 after reset.
- R2: On every capture, the counter value on `count_i` in that cycle is stored into both the newest stage (A2) and its shadow (B2). The old B2 value moves into the B-port stage (B1), unless B1 is frozen or an A read happens in the same cycle.
- R3: On the second and each later capture since enable, the old B2 value also moves into the period-start stage (A1).
- R4: The first capture after reset or after enable rises does not set `flag_o`. Every later capture sets it in the next cycle.
- R5: `flag_o` stays high until `flag_clr_i` is asserted. A capture and a clear in the same cycle leave it set.
- R6: `a_data_o` always shows A2 and `b_data_o` always shows B1. A read strobe changes only the lock state and B1, never the data of the cycle in which it is given.
- R7: An A read (`rd_a_i`) while enabled loads A1 into B1 and freezes B1 against capture transfers until a B read (`rd_b_i`). If both strobes are given in the same cycle, the A read wins.
- R8: A repeated A read while B1 is frozen loads A1 into B1 again, and B1 stays frozen.
- R9: A B read given before an A read does not release the freeze that the A read sets. A further B read is needed to release it.
- R10: While `enable_i` is low, no capture occurs, the freeze is released, the first-capture state is cleared and `flag_o` is 0.
- R11: After reset all stages are 0, `flag_o` is 0 and B1 is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Period-measurement mode enable |
| edge_pol_i | input | 1 | 1 selects rising edges, 0 selects falling edges |
| sig_i | input | 1 | Filtered input signal |
| count_i | input | CNT_W | Shared counter bus |
| rd_a_i | input | 1 | A-port read strobe |
| rd_b_i | input | 1 | B-port read strobe |
| flag_clr_i | input | 1 | Flag clear, write-one |
| a_data_o | output | CNT_W | A-port read data (A2) |
| b_data_o | output | CNT_W | B-port read data (B1) |
| flag_o | output | 1 | Full period captured |

## Verification
The channel is driven with rising-polarity pulse trains and then with falling-polarity pulse trains. Comparing the two shows whether edges of the wrong polarity and steady levels are correctly ignored. Reads are issued in the order A then B, in the order B then A, as repeated A reads, and as simultaneous strobes, with captures placed between the reads. This exposes freeze and release errors that a single read order would hide. Clears are given both alone and together with a capture, and the mode is toggled while edges arrive, to test flag priority and the re-arming of the first capture.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/pcc_edge_det.sv
module pcc_edge_det
  import pcc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  edge_pol_e pol_i,
  input  logic      sig_i,
  output logic      cap_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign cap_o = enable_i && (sig_i == logic'(pol_i)) && (sig_q != logic'(pol_i));

  AST_NO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o && $stable(pol_i) |=> !cap_o);  // R1
endmodule

// File: rtl/pcc_lock_ctrl.sv
module pcc_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic rd_a_i,
  input  logic rd_b_i,
  input  logic cap_i,
  output logic lock_o,
  output logic ld_a1_o,
  output logic ld_b2_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= 1'b0;
    else if (!enable_i) lock_q <= 1'b0;
    else if (rd_a_i)   lock_q <= 1'b1;
    else if (rd_b_i)   lock_q <= 1'b0;
  end

  // A read has priority over a capture transfer into B1
  assign ld_a1_o = enable_i && rd_a_i;
  assign ld_b2_o = cap_i && !lock_q && !ld_a1_o;
  assign lock_o  = lock_q;

  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && rd_a_i |=> lock_o);  // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && rd_b_i && !rd_a_i |=> !lock_o);  // R9
  AST_LOCK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !lock_o);  // R10
endmodule

// File: rtl/pcc_stage_regs.sv
module pcc_stage_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cap_i,
  input  logic             ld_a1_i,
  input  logic             ld_b2_i,
  input  logic             flag_clr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] a2_o,
  output logic [CNT_W-1:0] b1_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] a1_q, a2_q, b1_q, b2_q;
  logic             armed_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q <= '0;
      a2_q <= '0;
      b2_q <= '0;
    end else if (cap_i) begin
      a2_q <= count_i;
      b2_q <= count_i;
      if (armed_q) a1_q <= b2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      b1_q <= '0;
    else if (ld_a1_i) b1_q <= a1_q;
    else if (ld_b2_i) b1_q <= b2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (!enable_i) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cap_i) armed_q <= 1'b1;
      if (cap_i && armed_q) flag_q <= 1'b1;
      else if (flag_clr_i)  flag_q <= 1'b0;
    end
  end

  assign a2_o   = a2_q;
  assign b1_o   = b1_q;
  assign flag_o = flag_q;

  AST_CAP_A2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> a2_o == $past(count_i));  // R2
  AST_FIRST_NOFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !armed_q |=> !flag_o);  // R4
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && armed_q |=> flag_o);  // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && enable_i && !flag_clr_i |=> flag_o);  // R5
  AST_RDA_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a1_i |=> b1_o == $past(a1_q));  // R7
endmodule

// File: rtl/period_capture_channel.sv
module period_capture_channel
  import pcc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             edge_pol_i,
  input  logic             sig_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rd_a_i,
  input  logic             rd_b_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] a_data_o,
  output logic [CNT_W-1:0] b_data_o,
  output logic             flag_o
);
  logic cap, lock, ld_a1, ld_b2;

  pcc_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .pol_i    (edge_pol_e'(edge_pol_i)),
    .sig_i    (sig_i),
    .cap_o    (cap)
  );

  pcc_lock_ctrl u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .rd_a_i   (rd_a_i),
    .rd_b_i   (rd_b_i),
    .cap_i    (cap),
    .lock_o   (lock),
    .ld_a1_o  (ld_a1),
    .ld_b2_o  (ld_b2)
  );

  pcc_stage_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .cap_i      (cap),
    .ld_a1_i    (ld_a1),
    .ld_b2_i    (ld_b2),
    .flag_clr_i (flag_clr_i),
    .count_i    (count_i),
    .a2_o       (a_data_o),
    .b1_o       (b_data_o),
    .flag_o     (flag_o)
  );

  AST_B1_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock && !rd_a_i |=> $stable(b_data_o));  // R8
  AST_IDLE_A2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(a_data_o));  // R10
endmodule

// File: tb/tb_period_capture_channel.sv
module tb_period_capture_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, pol = 1'b1, sig = 1'b0, rd_a = 1'b0, rd_b = 1'b0, clr = 1'b0;
  logic [W-1:0] cnt = 16'h0100;
  logic [W-1:0] a_dat, b_dat;
  logic flag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural model
  logic [W-1:0] m_a1 = '0, m_a2 = '0, m_b1 = '0, m_b2 = '0;
  bit m_armed = 0, m_lock = 0, m_flag = 0, m_sq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  period_capture_channel #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .edge_pol_i(pol), .sig_i(sig),
    .count_i(cnt), .rd_a_i(rd_a), .rd_b_i(rd_b), .flag_clr_i(clr),
    .a_data_o(a_dat), .b_data_o(b_dat), .flag_o(flag)
  );

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "a_data", a_dat, m_a2);
    chk(tag, "b_data", b_dat, m_b1);
    chk(tag, "flag", {{(W-1){1'b0}}, flag}, {{(W-1){1'b0}}, m_flag});
  endtask

  // compute model next state from present inputs, clock, compare at negedge
  task automatic tick(input string tag);
    bit e;
    logic [W-1:0] n_a1, n_b1;
    e = en && (sig == pol) && (m_sq != pol);
    n_a1 = m_a1;
    n_b1 = m_b1;
    if (en && rd_a)        n_b1 = m_a1;
    else if (e && !m_lock) n_b1 = m_b2;
    if (e && m_armed)      n_a1 = m_b2;
    if (!en) begin
      m_flag = 0;
    end else if (e && m_armed) m_flag = 1;
    else if (clr)          m_flag = 0;
    if (!en)       m_lock = 0;
    else if (rd_a) m_lock = 1;
    else if (rd_b) m_lock = 0;
    if (!en)    m_armed = 0;
    else if (e) m_armed = 1;
    if (e) begin
      m_a2 = cnt;
      m_b2 = cnt;
    end
    m_a1 = n_a1;
    m_b1 = n_b1;
    m_sq = sig;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    cnt = cnt + 16'h0013;
    rd_a = 0; rd_b = 0; clr = 0;
  endtask

  task automatic pulse(input string tag);
    sig = pol;  tick(tag);
    tick(tag);
    sig = ~pol; tick(tag);
    tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    tick("R11");

    // rising polarity, first capture then period
    en = 1; pol = 1;
    tick("R10");
    pulse("R1");            // first capture, no flag
    pulse("R4");            // second: flag
    pulse("R3");
    sig = 0; tick("R1");    // steady level, no capture
    clr = 1; tick("R5");
    pulse("R2");
    sig = 1; clr = 1; tick("R5");   // capture and clear together
    tick("R5"); sig = 0; tick("R5");

    // A then B, captures in between
    rd_a = 1; tick("R7");
    pulse("R7"); pulse("R7");
    rd_a = 1; tick("R8");
    pulse("R8");
    rd_a = 1; tick("R8");
    rd_b = 1; tick("R7");
    pulse("R2");
    // A read on the capture cycle
    sig = 1; rd_a = 1; tick("R7");
    sig = 0; tick("R6");
    rd_b = 1; tick("R6");
    // both strobes together
    rd_a = 1; rd_b = 1; tick("R7");
    pulse("R7");
    rd_b = 1; tick("R9");

    // B then A: still frozen, second B releases
    rd_b = 1; tick("R9");
    rd_a = 1; tick("R9");
    pulse("R9"); pulse("R9");
    rd_b = 1; tick("R9");
    pulse("R9");

    // leave mode while frozen and flagged
    rd_a = 1; tick("R10");
    en = 0; tick("R10");
    pulse("R10"); pulse("R10");
    en = 1; tick("R10");
    pulse("R10");            // first after re-entry: no flag
    pulse("R4");

    // falling polarity
    pol = 0; sig = 1; tick("R1");
    tick("R1");
    pulse("R1"); pulse("R1"); pulse("R3");
    rd_a = 1; tick("R6");
    rd_b = 1; tick("R6");
    pulse("R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule